// File: doc/BRIEF.md
# Byte-Wide SPI Master with Completion Flag

This block is a serial peripheral interface master. Software controls it through a small register bus. Writing a byte to the data register starts a full-duplex transfer. The byte leaves on `mosi` most significant bit first, and a byte from the slave is collected from `miso` over the same clock edges. The serial clock comes from the system clock through a programmable half-period divider. All four combinations of idle polarity and sampling phase are supported.

When the final serial edge of a byte has passed, the collected byte is placed in a receive holding register and a completion flag is raised. Software drops that flag with a two-step handshake:

1. Read the status register while the flag is showing.
2. Then read the data register.

The mode settings are locked while the block is enabled. These are the master-select bit, the polarity, the phase and the divider. A write to the data register during an active transfer does not disturb the transfer. It only raises a collision bit.

Register map, chosen by `reg_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit0 enable, bit1 master select, bit2 polarity, bit3 phase |
| 1 | divider | half-period in system clocks |
| 2 | status | bit0 completion, bit1 write collision, bit2 busy |
| 3 | data | write starts a transfer; read returns the received byte |

`reg_rdata` always shows the register selected by `reg_addr`. A read has side effects only in a cycle where `reg_rd` is high.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control, divider, status and data registers all read 0, and `sck` and `mosi` are both 0.
- R2: A data write while enable=1, master=1 and no transfer is running starts a transfer. The busy bit (status bit2) reads 1 from the next cycle.
- R3: During a transfer, the written byte is driven on `mosi` most significant bit first. At the same time, 8 bits are collected from `miso` most significant bit first. A data read afterwards returns the collected byte. This holds in all four polarity/phase modes.
- R4: Whenever no transfer is running, `sck` rests at the polarity bit (control bit2).
- R5: Consecutive `sck` edges within a transfer are spaced by the divider value in system clocks. Divider values 0 and 1 act as 2.
- R6: Each transfer makes exactly 16 `sck` edges. On the last edge, busy drops, and the completion flag (status bit0) and the receive register are set together.
- R7: The completion flag stays set on a data read alone. It clears only on a data read that follows a status read which saw the flag (or the collision bit) set.
- R8: While enable=1, writes to the master, polarity and phase bits and to the divider register have no effect. The enable bit itself remains writable.
- R9: A data write during a busy transfer leaves the transfer's outgoing byte unchanged. It sets the collision bit (status bit1), which is cleared by the same sequence as in R7.
- R10: A data write while enable=0 or master=0 starts nothing. Busy stays 0 and `sck` makes no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for side effects) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Most internal faults in this block become visible on `sck` within one divider period of the fault. A miscounted edge index shows up within one byte as a wrong edge count, or as a shifted byte at the slave model or in the receive register. A wrong polarity or phase choice does the same. A stuck flag or a mis-armed clear handshake shows up on the very next status read. The bench therefore compares both directions of the data after every transfer. It also times every `sck` gap and reads the status register around each step of the clear sequence.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DIV  = 2'd1,
        A_STAT = 2'd2,
        A_DATA = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_MSTR = 1;
    localparam int CTRL_CPOL = 2;
    localparam int CTRL_CPHA = 3;

    localparam int STAT_DONE = 0;
    localparam int STAT_WCOL = 1;
    localparam int STAT_BUSY = 2;
endpackage

// File: rtl/spi_half_timer.sv
`timescale 1ns/1ps
module spi_half_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half,
    output logic          tick
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        // Half-periods below two system clocks are raised to two.
        lim   = (half < CW'(2)) ? CW'(2) : half;
        tick  = run && (cnt_q == lim - CW'(1));
        cnt_d = cnt_q + CW'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_in,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tick,
    input  logic         miso,
    output logic         busy,
    output logic         sck,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_out
);
    localparam int EW = $clog2(2 * W);
    localparam logic [EW-1:0] LAST = EW'(2 * W - 1);

    typedef struct packed {
        logic          busy;
        logic [EW-1:0] ecnt;
        logic          sck;
        logic          mosi;
        logic [W-1:0]  txs;
        logic [W-1:0]  rxs;
    } eng_t;

    eng_t st_d, st_q;
    logic lead;
    logic smp;
    logic [W-1:0] rx_nx;

    always_comb begin
        st_d   = st_q;
        done   = 1'b0;
        rx_out = st_q.rxs;
        lead   = ~st_q.ecnt[0];
        // Phase 0 samples on leading edges, phase 1 on trailing edges.
        smp    = lead ^ cpha;
        rx_nx  = {st_q.rxs[W-2:0], miso};

        if (!st_q.busy) begin
            st_d.sck = cpol;
            if (start) begin
                st_d.busy = 1'b1;
                st_d.ecnt = '0;
                st_d.rxs  = '0;
                if (!cpha) begin
                    st_d.mosi = tx_in[W-1];
                    st_d.txs  = {tx_in[W-2:0], 1'b0};
                end else begin
                    st_d.txs  = tx_in;
                end
            end
        end else if (tick) begin
            st_d.sck  = ~st_q.sck;
            st_d.ecnt = st_q.ecnt + 1'b1;
            if (smp) begin
                st_d.rxs = rx_nx;
            end else begin
                st_d.mosi = st_q.txs[W-1];
                st_d.txs  = {st_q.txs[W-2:0], 1'b0};
            end
            if (st_q.ecnt == LAST) begin
                st_d.busy = 1'b0;
                done      = 1'b1;
                rx_out    = smp ? rx_nx : st_q.rxs;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign sck  = st_q.sck;
    assign mosi = st_q.mosi;
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
    import spi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    localparam int PAD_CTRL = DATA_W - 4;
    localparam int PAD_STAT = DATA_W - 3;

    typedef struct packed {
        logic              en;
        logic              mstr;
        logic              cpol;
        logic              cpha;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rxd;
        logic              done;
        logic              wcol;
        logic              armed;
    } top_t;

    top_t st_d, st_q;
    reg_addr_e addr;
    logic xfer_start;
    logic data_wr;
    logic eng_busy;
    logic eng_done;
    logic tick;
    logic [DATA_W-1:0] eng_rx;
    logic cfg_cpol, cfg_en, flag_done, flag_wcol;

    assign addr = reg_addr_e'(reg_addr);

    always_comb begin
        st_d       = st_q;
        data_wr    = reg_wr && (addr == A_DATA);
        xfer_start = data_wr && st_q.en && st_q.mstr && !eng_busy;

        if (reg_wr && addr == A_CTRL) begin
            st_d.en = reg_wdata[CTRL_EN];
            if (!st_q.en) begin
                st_d.mstr = reg_wdata[CTRL_MSTR];
                st_d.cpol = reg_wdata[CTRL_CPOL];
                st_d.cpha = reg_wdata[CTRL_CPHA];
            end
        end
        if (reg_wr && addr == A_DIV && !st_q.en) begin
            st_d.div = reg_wdata[DIV_W-1:0];
        end
        if (data_wr && eng_busy) begin
            st_d.wcol = 1'b1;
        end
        // First step of the clear handshake: a status read that sees a flag.
        if (reg_rd && addr == A_STAT && (st_q.done || st_q.wcol)) begin
            st_d.armed = 1'b1;
        end
        // Second step: a data read after the armed status read.
        if (reg_rd && addr == A_DATA && st_q.armed) begin
            st_d.done  = 1'b0;
            st_d.wcol  = 1'b0;
            st_d.armed = 1'b0;
        end
        // A new completion wins over a clear in the same cycle.
        if (eng_done) begin
            st_d.done = 1'b1;
            st_d.rxd  = eng_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, st_q.cpha, st_q.cpol, st_q.mstr, st_q.en};
            A_DIV:   reg_rdata = DATA_W'(st_q.div);
            A_STAT:  reg_rdata = {{PAD_STAT{1'b0}}, eng_busy, st_q.wcol, st_q.done};
            default: reg_rdata = st_q.rxd;
        endcase
    end

    spi_half_timer #(.CW(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .half  (st_q.div),
        .tick  (tick)
    );

    spi_shift_engine #(.W(DATA_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (xfer_start),
        .tx_in  (reg_wdata),
        .cpol   (st_q.cpol),
        .cpha   (st_q.cpha),
        .tick   (tick),
        .miso   (miso),
        .busy   (eng_busy),
        .sck    (sck),
        .mosi   (mosi),
        .done   (eng_done),
        .rx_out (eng_rx)
    );

    assign cfg_cpol  = st_q.cpol;
    assign cfg_en    = st_q.en;
    assign flag_done = st_q.done;
    assign flag_wcol = st_q.wcol;
endmodule

// File: rtl/spi_byte_master_chk.sv
`timescale 1ns/1ps
module spi_byte_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic start,
    input logic data_wr,
    input logic sck,
    input logic cpol,
    input logic en,
    input logic done_flag,
    input logic wcol
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));

    p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    p_mode_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> $stable(cpol));

    p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> wcol);

    p_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !en && !busy) |=> !busy);
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (eng_busy),
    .start     (xfer_start),
    .data_wr   (data_wr),
    .sck       (sck),
    .cpol      (cfg_cpol),
    .en        (cfg_en),
    .done_flag (flag_done),
    .wcol      (flag_wcol)
);

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sck, mosi, miso;

    int total = 0;
    int bad   = 0;

    spi_byte_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #5 clk = ~clk;

    // {cpol, cpha, div[7:0], master byte[7:0], slave byte[7:0]}
    localparam logic [25:0] VEC [6] = '{
        {1'b0, 1'b0, 8'd4, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'd2, 8'hC3, 8'h81},
        {1'b1, 1'b0, 8'd3, 8'h5A, 8'hF0},
        {1'b1, 1'b1, 8'd5, 8'h01, 8'h80},
        {1'b0, 1'b0, 8'd0, 8'hFF, 8'h00},
        {1'b1, 1'b1, 8'd1, 8'h96, 8'h69}
    };

    // Slave model
    logic       slv_on = 1'b0;
    logic       slv_cpha;
    logic [7:0] slv_tx, slv_rx;
    int         slv_edges, slv_idx;
    longint     last_t, gap_min, gap_max;

    always @(sck) begin
        if (slv_on) begin
            if (slv_edges > 0) begin
                if ($time - last_t < gap_min) gap_min = $time - last_t;
                if ($time - last_t > gap_max) gap_max = $time - last_t;
            end
            last_t = $time;
            #1;
            if (((slv_edges % 2) == 0) ^ slv_cpha) begin
                slv_rx = {slv_rx[6:0], mosi};
            end else if (slv_idx >= 0) begin
                miso    = slv_tx[slv_idx];
                slv_idx = slv_idx - 1;
            end
            slv_edges = slv_edges + 1;
        end
    end

    task automatic chk(input string req, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic setup(input logic pol, input logic pha, input logic [7:0] dv);
        wr(2'd0, 8'h00);
        wr(2'd1, dv);
        wr(2'd0, {4'b0, pha, pol, 1'b1, 1'b0});
        wr(2'd0, {4'b0, pha, pol, 1'b1, 1'b1});
    endtask

    task automatic slave_arm(input logic pha, input logic [7:0] b);
        slv_cpha = pha; slv_tx = b; slv_rx = 8'h00; slv_edges = 0;
        gap_min = 64'd1000000; gap_max = 0;
        if (!pha) begin
            miso = b[7]; slv_idx = 6;
        end else begin
            slv_idx = 7;
        end
        slv_on = 1'b1;
    endtask

    task automatic wait_edges();
        for (int k = 0; k < 5000 && slv_edges < 16; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [25:0] e;
        int half;
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; miso = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sck", sck, 0);
        chk("R1 mosi", mosi, 0);
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 div", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        rd(2'd3, v); chk("R1 data", v, 0);

        // Vector table over all four modes and several dividers
        for (int i = 0; i < 6; i++) begin
            e = VEC[i];
            half = (e[23:16] < 2) ? 2 : int'(e[23:16]);
            setup(e[25], e[24], e[23:16]);
            chk("R4 idle level", sck, e[25]);
            slave_arm(e[24], e[7:0]);
            wr(2'd3, e[15:8]);
            rd(2'd2, v); chk("R2 busy", v, 8'h04);
            wait_edges();
            slv_on = 1'b0;
            chk("R6 edge count", slv_edges, 16);
            chk("R3 slave got", slv_rx, e[15:8]);
            chk("R5 min gap", gap_min, half * 10);
            chk("R5 max gap", gap_max, half * 10);
            rd(2'd2, v); chk("R6 flag set", v, 8'h01);
            rd(2'd3, v); chk("R3 master got", v, e[7:0]);
            rd(2'd2, v); chk("R7 flag cleared", v, 8'h00);
            chk("R4 idle after", sck, e[25]);
        end

        // R7: data read alone does not clear; status read must see the flag
        setup(1'b0, 1'b0, 8'd2);
        slave_arm(1'b0, 8'h11);
        wr(2'd3, 8'h22);
        rd(2'd2, v); chk("R7 busy", v, 8'h04);
        wait_edges();
        slv_on = 1'b0;
        rd(2'd3, v); chk("R7 data", v, 8'h11);
        rd(2'd2, v); chk("R7 still set", v, 8'h01);
        rd(2'd3, v);
        rd(2'd2, v); chk("R7 cleared", v, 8'h00);

        // R9: collision
        slave_arm(1'b0, 8'h5C);
        wr(2'd3, 8'hE7);
        repeat (5) @(negedge clk);
        wr(2'd3, 8'h18);
        rd(2'd2, v); chk("R9 wcol busy", v, 8'h06);
        wait_edges();
        slv_on = 1'b0;
        chk("R9 byte kept", slv_rx, 8'hE7);
        rd(2'd2, v); chk("R9 flags", v, 8'h03);
        rd(2'd3, v); chk("R9 data", v, 8'h5C);
        rd(2'd2, v); chk("R9 cleared", v, 8'h00);

        // R8: mode bits locked while enabled
        wr(2'd0, 8'h0F);
        rd(2'd0, v); chk("R8 ctrl kept", v, 8'h03);
        repeat (3) @(negedge clk);
        chk("R8 sck kept", sck, 0);
        wr(2'd1, 8'd9);
        rd(2'd1, v); chk("R8 div kept", v, 8'd2);

        // R10: no transfer when disabled or not master
        wr(2'd0, 8'h00);
        slave_arm(1'b0, 8'h00);
        wr(2'd3, 8'hAA);
        repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R10 disabled busy", v, 8'h00);
        chk("R10 disabled edges", slv_edges, 0);
        wr(2'd0, 8'h01);
        wr(2'd3, 8'hAA);
        repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R10 slave busy", v, 8'h00);
        chk("R10 slave edges", slv_edges, 0);
        slv_on = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule